// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block arbitrates eleven interrupt request flags for a small processor core and decides, once per machine cycle, whether the core should divert into a handler. Each clock edge is one machine cycle. Every cycle the block looks at the current flags, masks them with the per-source enables and a global enable, and splits the survivors into two priority levels. Within a level, a fixed natural order breaks ties, and any high-level request outranks every low-level one. Nothing is carried over from earlier cycles. A request that loses or is held off in one cycle is judged again from scratch in the next cycle. If its flag has dropped by then, the request is lost.

A call is issued only at an instruction boundary, and only when the current instruction is neither a write to the enable or level registers nor an interrupt return. The winning source must also be allowed to preempt whatever handler is running. When all of this holds, the block raises a one-cycle call request carrying a 16-bit vector address. It also gives a matching acknowledge with the winner's index and a hint telling the flag's owner whether hardware should clear that flag.

The block keeps one in-service bit per level. A taken call sets the bit for the winner's level. Only the core's interrupt-return strobe clears an in-service bit, and it clears the higher active level first. An ordinary subroutine return therefore leaves the block treating the handler as still active.

Top module: `ipc_vector_ctrl`

## Requirements
- R1: During and right after reset, call_req, ack_valid, ack_hwclr, call_vec, ack_idx and svc_state are all zero.
- R2: Sources that are qualified at the same level are ranked by flag bit index, and the lowest index wins. The ranking from highest to lowest is: bit 0 external 0, bit 1 timer 0, bit 2 external 1, bit 3 timer 1, bit 4 serial, bit 5 external 2, bit 6 external 3, bit 7 caller-id, bit 8 divider, bit 9 compare, bit 10 watchdog.
- R3: The call vector for bit indices 0 to 10 is 0x03, 0x0B, 0x13, 0x1B, 0x3B, 0x43, 0x4B, 0x53, 0x5B, 0x63 and 0x6B, in that index order.
- R4: A qualified source whose irq_lvl bit is 1 (high level) wins over every qualified source whose bit is 0, whatever their indices.
- R5: A source can be selected only when its flag, its irq_en bit and glob_en are all 1.
- R6: A call is taken only in a cycle where instr_last=1, instr_block=0 and reti_strobe=0.
- R7: A low-level winner is taken only when svc_state is 00. A high-level winner is taken only when svc_state[1] is 0, so a high-level source can preempt a low-level handler.
- R8: Requests are not latched. A request that is denied in one cycle and has dropped by the next qualifying cycle never produces a call.
- R9: The outputs are registered. When a call is taken in cycle k, then in cycle k+1 call_req and ack_valid are 1 for exactly that cycle, with call_vec and ack_idx set to the winner's vector and index. In all other cycles call_vec and ack_idx are zero.
- R10: ack_hwclr is 1 with each acknowledge, except when ack_idx is 7 or 10, where it is 0.
- R11: svc_state[1] is the high-level in-service bit and svc_state[0] is the low-level one. A taken call sets the bit for the winner's level. reti_strobe clears bit 1 if it is set, and otherwise clears bit 0. With no strobe, neither bit ever clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one machine cycle per edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_flag | input | 11 | Request flags, bit index = natural rank |
| irq_en | input | 11 | Per-source enables |
| irq_lvl | input | 11 | Per-source level, 1 = high |
| glob_en | input | 1 | Global interrupt enable |
| instr_last | input | 1 | Current cycle is the last one of the instruction |
| instr_block | input | 1 | Current instruction writes an enable or level register |
| reti_strobe | input | 1 | Current instruction is an interrupt return |
| call_req | output | 1 | One-cycle request to enter a handler |
| call_vec | output | 16 | Handler address for the call |
| ack_valid | output | 1 | Acknowledge pulse, same cycle as call_req |
| ack_idx | output | 4 | Index of the acknowledged source |
| ack_hwclr | output | 1 | Acknowledged flag is to be cleared by hardware |
| svc_state | output | 2 | In-service bits {high, low} |

## Verification
The in-service bits appear directly on svc_state. A wrong set or clear therefore shows one cycle after the cycle that caused it. A stale bit shows up later as a call that should have been taken but is missing, or as one taken when it should have been withheld. A bad ranking, a faulty masking term or an incorrect vector shows one cycle after the qualifying cycle, as a wrong call_vec or ack_idx, or as a missing or extra call_req. Because of this, each driven cycle is checked against the expected outputs one clock later. That check covers svc_state as well as the call fields.

// File: rtl/ipc_pkg.sv
package ipc_pkg;

  localparam int unsigned NSRC  = 11;
  localparam int unsigned IDX_W = $clog2(NSRC);
  localparam int unsigned VEC_W = 16;

  // sources whose flag is left for software to clear (caller-id, watchdog)
  localparam logic [NSRC-1:0] SW_ONLY_MASK = 11'b100_1000_0000;

  typedef enum logic { LVL_LO = 1'b0, LVL_HI = 1'b1 } lvl_e;

  // handler address: 8-byte slots from 0x03, with a 24-byte gap after slot 3
  function automatic int unsigned vec_of(input int unsigned idx);
    int unsigned a;
    a = idx * 8 + 3;
    if (idx >= 4) a = a + 24;
    return a;
  endfunction

endpackage

// File: rtl/ipc_qualify.sv
module ipc_qualify #(
  parameter int unsigned N = 11
) (
  input  logic [N-1:0] flag,
  input  logic [N-1:0] en,
  input  logic [N-1:0] lvl,
  input  logic         glob,
  output logic [N-1:0] hi_req,
  output logic [N-1:0] lo_req
);

  logic [N-1:0] armed;

  generate
    for (genvar g = 0; g < N; g++) begin : g_arm
      assign armed[g]  = flag[g] & en[g] & glob;
      assign hi_req[g] = armed[g] & lvl[g];
      assign lo_req[g] = armed[g] & ~lvl[g];
    end
  endgenerate

endmodule

// File: rtl/ipc_fixed_pick.sv
module ipc_fixed_pick #(
  parameter int unsigned N  = 11,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);

  logic [N:0]   seen;
  logic [N-1:0] first;

  assign seen[0] = 1'b0;

  generate
    for (genvar g = 0; g < N; g++) begin : g_chain
      assign first[g]  = req[g] & ~seen[g];
      assign seen[g+1] = seen[g] | req[g];
    end
  endgenerate

  assign found = seen[N];

  always_comb begin
    idx = '0;
    for (int i = 0; i < int'(N); i++) begin
      if (first[i]) idx = idx | IW'(i);
    end
  end

endmodule

// File: rtl/ipc_svc_track.sv
module ipc_svc_track (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       take,
  input  logic       take_lvl,
  input  logic       reti,
  output logic [1:0] svc
);

  logic [1:0] svc_nxt;

  always_comb begin
    svc_nxt = svc;
    if (take) begin
      svc_nxt[take_lvl] = 1'b1;
    end else if (reti) begin
      if (svc[1]) svc_nxt[1] = 1'b0;
      else        svc_nxt[0] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) svc <= 2'b00;
    else        svc <= svc_nxt;
  end

endmodule

// File: rtl/ipc_vector_ctrl.sv
module ipc_vector_ctrl
  import ipc_pkg::*;
#(
  parameter int unsigned     N_SRC    = NSRC,
  parameter int unsigned     IDX_BITS = $clog2(N_SRC),
  parameter int unsigned     ADDR_W   = VEC_W,
  parameter logic [N_SRC-1:0] SW_MASK = SW_ONLY_MASK
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  irq_flag,
  input  logic [N_SRC-1:0]  irq_en,
  input  logic [N_SRC-1:0]  irq_lvl,
  input  logic              glob_en,
  input  logic              instr_last,
  input  logic              instr_block,
  input  logic              reti_strobe,
  output logic              call_req,
  output logic [ADDR_W-1:0] call_vec,
  output logic              ack_valid,
  output logic [IDX_BITS-1:0] ack_idx,
  output logic              ack_hwclr,
  output logic [1:0]        svc_state
);

  // named internal events
  logic [N_SRC-1:0]    hi_req, lo_req;
  logic                hi_found, lo_found;
  logic [IDX_BITS-1:0] hi_idx, lo_idx;
  logic                any_req;
  logic                win_lvl;
  logic [IDX_BITS-1:0] win_idx;
  logic                boundary_ok;
  logic                preempt_ok;
  logic                take;
  logic [ADDR_W-1:0]   win_vec;
  logic                win_hwclr;

  ipc_qualify #(.N(N_SRC)) u_qual (
    .flag   (irq_flag),
    .en     (irq_en),
    .lvl    (irq_lvl),
    .glob   (glob_en),
    .hi_req (hi_req),
    .lo_req (lo_req)
  );

  ipc_fixed_pick #(.N(N_SRC), .IW(IDX_BITS)) u_pick_hi (
    .req   (hi_req),
    .found (hi_found),
    .idx   (hi_idx)
  );

  ipc_fixed_pick #(.N(N_SRC), .IW(IDX_BITS)) u_pick_lo (
    .req   (lo_req),
    .found (lo_found),
    .idx   (lo_idx)
  );

  assign any_req     = hi_found | lo_found;
  assign win_lvl     = hi_found ? LVL_HI : LVL_LO;
  assign win_idx     = hi_found ? hi_idx : lo_idx;
  assign boundary_ok = instr_last & ~instr_block & ~reti_strobe;
  assign preempt_ok  = (win_lvl == LVL_HI) ? ~svc_state[1] : (svc_state == 2'b00);
  assign take        = any_req & boundary_ok & preempt_ok;
  assign win_vec     = ADDR_W'(vec_of(int'(win_idx)));
  assign win_hwclr   = ~SW_MASK[win_idx];

  ipc_svc_track u_svc (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .take_lvl (win_lvl),
    .reti     (reti_strobe),
    .svc      (svc_state)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      call_req  <= 1'b0;
      ack_valid <= 1'b0;
      call_vec  <= '0;
      ack_idx   <= '0;
      ack_hwclr <= 1'b0;
    end else begin
      call_req  <= take;
      ack_valid <= take;
      call_vec  <= take ? win_vec : '0;
      ack_idx   <= take ? win_idx : '0;
      ack_hwclr <= take & win_hwclr;
    end
  end

endmodule

// File: rtl/ipc_vector_ctrl_chk.sv
module ipc_vector_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       instr_last,
  input logic       instr_block,
  input logic       reti_strobe,
  input logic       call_req,
  input logic [3:0] ack_idx,
  input logic       ack_hwclr,
  input logic [1:0] svc_state,
  input logic       take,
  input logic       win_lvl
);

  assert_call_at_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |-> ($past(instr_last) && !$past(instr_block) && !$past(reti_strobe)));

  assert_no_call_high_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |-> !$past(svc_state[1]));

  assert_low_needs_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (call_req && !svc_state[1]) |-> ($past(svc_state) == 2'b00));

  assert_hold_without_reti_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(reti_strobe) |-> ((svc_state & $past(svc_state)) == $past(svc_state)));

  assert_reti_clears_top_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(reti_strobe) && ($past(svc_state) == 2'b11)) |-> (svc_state == 2'b01));

  assert_take_marks_level_R11: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> svc_state[$past(win_lvl)]);

  assert_swclr_sources_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ack_hwclr |-> (call_req && ack_idx != 4'd7 && ack_idx != 4'd10));

endmodule

bind ipc_vector_ctrl ipc_vector_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .instr_last  (instr_last),
  .instr_block (instr_block),
  .reti_strobe (reti_strobe),
  .call_req    (call_req),
  .ack_idx     (ack_idx),
  .ack_hwclr   (ack_hwclr),
  .svc_state   (svc_state),
  .take        (take),
  .win_lvl     (win_lvl)
);

// File: tb/ipc_vector_ctrl_tb.sv
`timescale 1ns/1ps
module ipc_vector_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] irq_flag = '0, irq_en = '0, irq_lvl = '0;
  logic        glob_en = 1'b0, instr_last = 1'b0, instr_block = 1'b0, reti_strobe = 1'b0;
  logic        call_req, ack_valid, ack_hwclr;
  logic [15:0] call_vec;
  logic [3:0]  ack_idx;
  logic [1:0]  svc_state;

  always #10 clk = ~clk;

  ipc_vector_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .irq_flag(irq_flag), .irq_en(irq_en), .irq_lvl(irq_lvl),
    .glob_en(glob_en), .instr_last(instr_last), .instr_block(instr_block),
    .reti_strobe(reti_strobe), .call_req(call_req), .call_vec(call_vec),
    .ack_valid(ack_valid), .ack_idx(ack_idx), .ack_hwclr(ack_hwclr), .svc_state(svc_state)
  );

  typedef struct {
    logic        call;
    logic [15:0] vec;
    logic [3:0]  idx;
    logic        hw;
    logic [1:0]  svc;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  logic [1:0] m_svc = 2'b00;

  function automatic logic [15:0] vec_tbl(input int i);
    case (i)
      0: return 16'h0003;  1: return 16'h000B;  2: return 16'h0013;
      3: return 16'h001B;  4: return 16'h003B;  5: return 16'h0043;
      6: return 16'h004B;  7: return 16'h0053;  8: return 16'h005B;
      9: return 16'h0063;  default: return 16'h006B;
    endcase
  endfunction

  // driver: applies one machine cycle of stimulus and queues the expected result
  task automatic step(input logic [10:0] f, input logic [10:0] e, input logic [10:0] l,
                      input logic g, input logic last, input logic blk, input logic rt,
                      input string tag);
    exp_t it;
    bit   found;
    int   w, wl;
    bit   ok;
    @(negedge clk);
    irq_flag = f; irq_en = e; irq_lvl = l; glob_en = g;
    instr_last = last; instr_block = blk; reti_strobe = rt;
    found = 0; w = 0; wl = 0;
    for (int lv = 1; lv >= 0; lv--)
      for (int i = 0; i < 11; i++)
        if (!found && f[i] && e[i] && g && (l[i] == lv[0])) begin
          found = 1; w = i; wl = lv;
        end
    ok = found && last && !blk && !rt && ((wl == 1) ? !m_svc[1] : (m_svc == 2'b00));
    it.call = ok; it.vec = 16'h0; it.idx = 4'h0; it.hw = 1'b0; it.tag = tag;
    if (ok) begin
      it.vec = vec_tbl(w); it.idx = 4'(w); it.hw = (w != 7) && (w != 10);
      m_svc[wl] = 1'b1;
    end else if (rt) begin
      if (m_svc[1]) m_svc[1] = 1'b0; else m_svc[0] = 1'b0;
    end
    it.svc = m_svc;
    exp_q.push_back(it);
  endtask

  // monitor: compares one cycle after each driven cycle
  initial begin
    forever begin
      exp_t it;
      @(posedge clk);
      #5;
      if (exp_q.size() > 0) begin
        it = exp_q.pop_front();
        n_cmp++;
        if (call_req !== it.call || ack_valid !== it.call || call_vec !== it.vec ||
            ack_idx !== it.idx || ack_hwclr !== it.hw || svc_state !== it.svc) begin
          n_bad++;
          $display("FAIL %s: got call=%b ack=%b vec=%h idx=%0d hw=%b svc=%b, exp call=%b vec=%h idx=%0d hw=%b svc=%b",
                   it.tag, call_req, ack_valid, call_vec, ack_idx, ack_hwclr, svc_state,
                   it.call, it.vec, it.idx, it.hw, it.svc);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not finish, exp done got hung");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  localparam logic [10:0] ALL = 11'h7FF;
  localparam logic [10:0] NON = 11'h000;

  initial begin
    repeat (3) @(posedge clk);
    #5;
    n_cmp++;
    if (call_req !== 1'b0 || ack_valid !== 1'b0 || call_vec !== 16'h0 || ack_idx !== 4'h0 ||
        ack_hwclr !== 1'b0 || svc_state !== 2'b00) begin
      n_bad++;
      $display("FAIL R1: got call=%b vec=%h idx=%0d svc=%b, exp all zero",
               call_req, call_vec, ack_idx, svc_state);
    end
    @(negedge clk);
    rst_n = 1'b1;
    step(NON, NON, NON, 0, 0, 0, 0, "R1 idle after reset");

    // R3 / R9 / R10: each source alone, low level, then an interrupt return
    for (int i = 0; i < 11; i++) begin
      step(11'(1 << i), ALL, NON, 1, 1, 0, 0, "R3 R9 R10 single source");
      step(NON, ALL, NON, 1, 1, 0, 0, "R9 pulse is one cycle");
      step(NON, ALL, NON, 1, 0, 0, 1, "R11 reti clears low");
    end

    // R2: natural order within one level
    step(ALL, ALL, NON, 1, 1, 0, 0, "R2 all low, index 0 wins");
    step(NON, NON, NON, 0, 0, 0, 1, "R11 reti");
    step(11'h7FE, ALL, NON, 1, 1, 0, 0, "R2 index 1 wins");
    step(NON, NON, NON, 0, 0, 0, 1, "R11 reti");
    step(11'h600, ALL, NON, 1, 1, 0, 0, "R2 index 9 over 10");
    step(NON, NON, NON, 0, 0, 0, 1, "R11 reti");
    step(11'h600, ALL, ALL, 1, 1, 0, 0, "R2 high level ties, index 9");
    step(NON, NON, NON, 0, 0, 0, 1, "R11 reti high");

    // R4: level beats index
    step(11'h401, ALL, 11'h400, 1, 1, 0, 0, "R4 high index 10 beats low index 0");
    step(NON, NON, NON, 0, 0, 0, 1, "R11 reti");

    // R5: enables
    step(11'h003, 11'h7FE, NON, 1, 1, 0, 0, "R5 disabled index 0 skipped");
    step(NON, NON, NON, 0, 0, 0, 1, "R11 reti");
    step(ALL, ALL, ALL, 0, 1, 0, 0, "R5 global off, no call");
    step(11'h001, NON, NON, 1, 1, 0, 0, "R5 own enable off, no call");

    // R6: boundary conditions
    step(11'h004, ALL, NON, 1, 0, 0, 0, "R6 not last cycle");
    step(11'h004, ALL, NON, 1, 1, 1, 0, "R6 blocking instruction");
    step(11'h004, ALL, NON, 1, 1, 0, 1, "R6 reti instruction");
    step(11'h004, ALL, NON, 1, 1, 0, 0, "R6 allowed now");
    step(NON, NON, NON, 0, 0, 0, 1, "R11 reti");

    // R7 / R11: nesting and plain return
    step(11'h010, ALL, NON, 1, 1, 0, 0, "R7 low taken");
    step(11'h001, ALL, NON, 1, 1, 0, 0, "R7 low blocked by low handler");
    step(NON, NON, NON, 0, 1, 0, 0, "R11 plain return keeps state");
    step(NON, NON, NON, 0, 1, 0, 0, "R11 plain return keeps state");
    step(11'h100, ALL, 11'h100, 1, 1, 0, 0, "R7 high preempts low");
    step(11'h001, ALL, 11'h001, 1, 1, 0, 0, "R7 high blocked by high");
    step(11'h002, ALL, NON, 1, 1, 0, 1, "R11 reti clears high first");
    step(11'h002, ALL, NON, 1, 1, 0, 0, "R7 low still blocked");
    step(NON, NON, NON, 0, 0, 0, 1, "R11 reti clears low");
    step(NON, NON, NON, 0, 0, 0, 1, "R11 reti when idle");

    // R8: no memory of denied requests
    step(11'h020, ALL, NON, 1, 0, 0, 0, "R8 denied mid-instruction");
    step(NON, ALL, NON, 1, 1, 0, 0, "R8 dropped request not served");
    step(11'h040, ALL, NON, 1, 1, 1, 0, "R8 denied by block");
    step(11'h080, ALL, NON, 1, 1, 0, 0, "R8 only current flag served");
    step(NON, NON, NON, 0, 0, 0, 1, "R11 reti");

    @(negedge clk);
    irq_flag = '0; irq_en = '0; irq_lvl = '0; glob_en = 0;
    instr_last = 0; instr_block = 0; reti_strobe = 0;
    repeat (3) @(posedge clk);
    #6;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule